// File: doc/BRIEF.md
# 64-bit Integer ALU with Overflow Trap

This block is the integer execution unit of a 64-bit load/store core. Each cycle it can take one operation: two 64-bit source operands, where the second one may be replaced by a 16-bit immediate. It also takes a 4-bit operation code, a word/double width select, a 5-bit instruction shift field and a shift-amount source select. One clock edge later it presents a 64-bit result, a register write strobe and an overflow-trap flag.

Word-width operations work on the low 32 bits of their operands. Their 32-bit result is then sign-extended to 64 bits. The trapping add and subtract check for signed overflow at the selected width. When overflow occurs, the write is withheld and the trap flag is raised instead. The result register keeps its previous value, so a downstream writeback stage never sees a partial result.

The operation codes are 0 ADD (trapping), 1 ADDU, 2 SUB (trapping), 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 LUI, 11 SLL, 12 SRL and 13 SRA. Codes 14 and 15 are reserved. The shift-amount select is 0 for the instruction field, 1 for the instruction field plus 32, and 2 or 3 for the low bits of source A.

Top module: `alu64_trap`

## Requirements
- R1: With wordMode=0, codes 0 to 3 give A+B or A−B modulo 2^64.
- R2: With wordMode=1, codes 0 to 3 compute on A[31:0] and B[31:0], and the 32-bit result is sign-extended from bit 31.
- R3: For codes 0 and 2, signed overflow at the selected width is detected when the two addends, with B inverted for a subtract, have equal sign bits and the sum's sign bit differs. Overflow gives writeEn=0 and ovfTrap=1 in the next cycle, and result keeps its earlier value.
- R4: Codes other than 0 and 2, including ADDU and SUBU with overflowing operands, never set ovfTrap.
- R5: When useImm=1, the immediate is sign-extended from 16 bits for codes 0 to 3, 8 and 9, and zero-extended for codes 4 to 7; it then replaces B.
- R6: Codes 4 to 7 give A&B, A|B, A^B and ~(A|B) over all 64 bits, whatever the wordMode setting.
- R7: Code 8 gives 1 when A<B as signed 64-bit values, else 0. Code 9 gives 1 when A<B as unsigned 64-bit values, else 0. For code 9 a sign-extended immediate is compared as an unsigned value.
- R8: Code 10 gives the sign-extended immediate shifted left by 16.
- R9: Shifts (11 left, 12 logical right, 13 arithmetic right) operate on srcB. The amount is the shamt field (select 0), shamt+32 (select 1) or A[5:0] (select 2 or 3). With wordMode=0 the shift is over 64 bits.
- R10: With wordMode=1, a shift uses only the low 5 bits of the amount and operates on B[31:0]. The 32-bit result is sign-extended from bit 31.
- R11: Outputs update one clock after the inputs. opValid=0 or a reserved code (14, 15) gives writeEn=0 and ovfTrap=0, and result holds. result loads only when writeEn is set.
- R12: Synchronous active-high reset clears result, writeEn and ovfTrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| wordMode | input | 1 | 1 selects 32-bit operation with sign extension |
| useImm | input | 1 | Replace srcB by the extended immediate |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand / shift source |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Instruction shift field |
| amtSel | input | 2 | Shift amount source select |
| result | output | 64 | Registered result |
| writeEn | output | 1 | Registered destination write strobe |
| ovfTrap | output | 1 | Registered overflow exception |

## Verification
Every operation result passes through one output register. A wrong decode, a wrong extension or a wrong overflow term therefore shows on the result, writeEn or ovfTrap in the cycle right after the operation. The exception is a wrong hold of the result register. That fault stays invisible until a cycle with writeEn low, and it then shows as a changed result. The bench sweeps every code, both widths, both operand sources and every amount select over a set of boundary operands. It compares each cycle with an arithmetic model, so a fault appears within one operation of the pattern that provokes it.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_LUI  = 4'd10,
    OP_SLL  = 4'd11,
    OP_SRL  = 4'd12,
    OP_SRA  = 4'd13
  } aluOp_e;

  typedef enum logic [1:0] {
    AMT_FIXED  = 2'd0,
    AMT_PLUS32 = 2'd1,
    AMT_REG    = 2'd2,
    AMT_REG2   = 2'd3
  } amtSrc_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logicOp_e;

  typedef enum logic [2:0] {
    RS_ADDER = 3'd0,
    RS_LOGIC = 3'd1,
    RS_CMP   = 3'd2,
    RS_UPPER = 3'd3,
    RS_SHIFT = 3'd4
  } resSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     active;
    logic     subtract;
    logic     trapOn;
    logic     immSigned;
    logic     cmpUnsigned;
    logic     shLeft;
    logic     shArith;
    logicOp_e logicOp;
    resSel_e  resSel;
  } aluCtrl_t;

endpackage

// File: rtl/alu64_ctrl.sv
module alu64_ctrl
  import alu64_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{active: 1'b0, subtract: 1'b0, trapOn: 1'b0, immSigned: 1'b0,
             cmpUnsigned: 1'b0, shLeft: 1'b0, shArith: 1'b0,
             logicOp: LG_AND, resSel: RS_ADDER};
    case (opCode)
      OP_ADD:  begin ctrl.active = opValid; ctrl.trapOn = 1'b1; ctrl.immSigned = 1'b1; end
      OP_ADDU: begin ctrl.active = opValid; ctrl.immSigned = 1'b1; end
      OP_SUB:  begin
        ctrl.active = opValid; ctrl.trapOn = 1'b1;
        ctrl.subtract = 1'b1; ctrl.immSigned = 1'b1;
      end
      OP_SUBU: begin ctrl.active = opValid; ctrl.subtract = 1'b1; ctrl.immSigned = 1'b1; end
      OP_AND:  begin ctrl.active = opValid; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_AND; end
      OP_OR:   begin ctrl.active = opValid; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_OR;  end
      OP_XOR:  begin ctrl.active = opValid; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_XOR; end
      OP_NOR:  begin ctrl.active = opValid; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_NOR; end
      OP_SLT:  begin ctrl.active = opValid; ctrl.resSel = RS_CMP; ctrl.immSigned = 1'b1; end
      OP_SLTU: begin
        ctrl.active = opValid; ctrl.resSel = RS_CMP;
        ctrl.immSigned = 1'b1; ctrl.cmpUnsigned = 1'b1;
      end
      OP_LUI:  begin ctrl.active = opValid; ctrl.resSel = RS_UPPER; end
      OP_SLL:  begin ctrl.active = opValid; ctrl.resSel = RS_SHIFT; ctrl.shLeft = 1'b1; end
      OP_SRL:  begin ctrl.active = opValid; ctrl.resSel = RS_SHIFT; end
      OP_SRA:  begin ctrl.active = opValid; ctrl.resSel = RS_SHIFT; ctrl.shArith = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu64_datapath.sv
module alu64_datapath
  import alu64_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HALF  = 32,
  parameter int IMM_W = 16
) (
  input  aluCtrl_t                  ctrl,
  input  logic                      wordMode,
  input  logic                      useImm,
  input  logic [XLEN-1:0]           srcA,
  input  logic [XLEN-1:0]           srcB,
  input  logic [IMM_W-1:0]          imm,
  input  logic [$clog2(HALF)-1:0]   shamt,
  input  logic [1:0]                amtSel,
  output logic [XLEN-1:0]           nextResult,
  output logic                      nextWrite,
  output logic                      nextTrap
);

  localparam int SHW  = $clog2(XLEN);
  localparam int SHWH = $clog2(HALF);
  localparam int EXTW = XLEN - HALF;

  logic [XLEN-1:0] immSx, immZx, opB, addB, sumFull, addRes;
  logic [XLEN-1:0] logicRes, cmpRes, upperRes, shiftRes;
  logic            signA, signB, signS, ovfRaw, lessThan;
  logic [SHW-1:0]  amt;
  logic [SHWH-1:0] amtW;
  logic [HALF-1:0] lowB, wordShift;
  logic [XLEN-1:0] dblShift;

  // Operand B selection with immediate extension
  always_comb begin
    immSx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    immZx = {{(XLEN-IMM_W){1'b0}}, imm};
    if (useImm) opB = ctrl.immSigned ? immSx : immZx;
    else        opB = srcB;
  end

  // Adder with width-dependent overflow detection
  always_comb begin
    addB    = ctrl.subtract ? ~opB : opB;
    sumFull = srcA + addB + XLEN'(ctrl.subtract);
    signA   = wordMode ? srcA[HALF-1]    : srcA[XLEN-1];
    signB   = wordMode ? addB[HALF-1]    : addB[XLEN-1];
    signS   = wordMode ? sumFull[HALF-1] : sumFull[XLEN-1];
    ovfRaw  = (signA == signB) && (signS != signA);
    addRes  = wordMode ? {{EXTW{sumFull[HALF-1]}}, sumFull[HALF-1:0]} : sumFull;
  end

  // Logic, compare, upper immediate
  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicRes = srcA & opB;
      LG_OR:   logicRes = srcA | opB;
      LG_XOR:  logicRes = srcA ^ opB;
      default: logicRes = ~(srcA | opB);
    endcase
    lessThan = ctrl.cmpUnsigned ? (srcA < opB) : ($signed(srcA) < $signed(opB));
    cmpRes   = {{(XLEN-1){1'b0}}, lessThan};
    upperRes = {immSx[XLEN-IMM_W-1:0], {IMM_W{1'b0}}};
  end

  // Shifter
  always_comb begin
    case (amtSel)
      AMT_FIXED:  amt = SHW'(shamt);
      AMT_PLUS32: amt = SHW'(shamt) + SHW'(HALF);
      default:    amt = srcA[SHW-1:0];
    endcase
    amtW = amt[SHWH-1:0];
    lowB = srcB[HALF-1:0];
    if (ctrl.shLeft)       wordShift = lowB << amtW;
    else if (ctrl.shArith) wordShift = $signed(lowB) >>> amtW;
    else                   wordShift = lowB >> amtW;
    if (ctrl.shLeft)       dblShift = srcB << amt;
    else if (ctrl.shArith) dblShift = $signed(srcB) >>> amt;
    else                   dblShift = srcB >> amt;
    shiftRes = wordMode ? {{EXTW{wordShift[HALF-1]}}, wordShift} : dblShift;
  end

  always_comb begin
    case (ctrl.resSel)
      RS_LOGIC: nextResult = logicRes;
      RS_CMP:   nextResult = cmpRes;
      RS_UPPER: nextResult = upperRes;
      RS_SHIFT: nextResult = shiftRes;
      default:  nextResult = addRes;
    endcase
    nextTrap  = ctrl.active && ctrl.trapOn && ovfRaw;
    nextWrite = ctrl.active && !(ctrl.trapOn && ovfRaw);
  end

endmodule

// File: rtl/alu64_trap.sv
module alu64_trap
  import alu64_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          opValid,
  input  logic [3:0]                    opCode,
  input  logic                          wordMode,
  input  logic                          useImm,
  input  logic [XLEN-1:0]               srcA,
  input  logic [XLEN-1:0]               srcB,
  input  logic [IMM_W-1:0]              imm,
  input  logic [$clog2(XLEN/2)-1:0]     shamt,
  input  logic [1:0]                    amtSel,
  output logic [XLEN-1:0]               result,
  output logic                          writeEn,
  output logic                          ovfTrap
);

  localparam int HALF = XLEN / 2;

  aluCtrl_t        ctrl;
  logic [XLEN-1:0] nextResult;
  logic            nextWrite, nextTrap;

  alu64_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  alu64_datapath #(.XLEN(XLEN), .HALF(HALF), .IMM_W(IMM_W)) u_dp (
    .ctrl       (ctrl),
    .wordMode   (wordMode),
    .useImm     (useImm),
    .srcA       (srcA),
    .srcB       (srcB),
    .imm        (imm),
    .shamt      (shamt),
    .amtSel     (amtSel),
    .nextResult (nextResult),
    .nextWrite  (nextWrite),
    .nextTrap   (nextTrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      writeEn <= 1'b0;
      ovfTrap <= 1'b0;
    end else begin
      writeEn <= nextWrite;
      ovfTrap <= nextTrap;
      if (nextWrite) result <= nextResult;
    end
  end

endmodule

// File: rtl/alu64_trap_chk.sv
module alu64_trap_chk #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            opValid,
  input logic [3:0]      opCode,
  input logic            wordMode,
  input logic [XLEN-1:0] result,
  input logic            writeEn,
  input logic            ovfTrap
);

  // R3: a trap and a write never occur together
  a_r3_trap_blocks_write: assert property (@(posedge clk) disable iff (rst)
    !(writeEn && ovfTrap));

  // R3 / R11: result changes only in a cycle that writes
  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !writeEn |-> $stable(result));

  // R4: only codes 0 and 2 may raise the trap
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (opCode != 4'd0 && opCode != 4'd2) |=> !ovfTrap);

  // R11: idle cycle produces no write and no trap
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> (!writeEn && !ovfTrap));

  // R2 / R10: word arithmetic and shift results are sign-extended
  a_r2_word_sext: assert property (@(posedge clk) disable iff (rst)
    (opValid && wordMode && (opCode <= 4'd3 || (opCode >= 4'd11 && opCode <= 4'd13)))
    |=> (!writeEn || result[XLEN-1:HALF] == {(XLEN-HALF){result[HALF-1]}}));

  // R7: compare results are 0 or 1
  a_r7_cmp_bool: assert property (@(posedge clk) disable iff (rst)
    (opValid && (opCode == 4'd8 || opCode == 4'd9)) |=> (result[XLEN-1:1] == '0));

  // R12: cleared after reset
  a_r12_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!writeEn && !ovfTrap && result == '0));

endmodule

bind alu64_trap alu64_trap_chk #(.XLEN(XLEN), .HALF(HALF)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opValid  (opValid),
  .opCode   (opCode),
  .wordMode (wordMode),
  .result   (result),
  .writeEn  (writeEn),
  .ovfTrap  (ovfTrap)
);

// File: tb/tb_alu64_trap.sv
`timescale 1ns/1ps
module tb_alu64_trap;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic        wordMode = 1'b0;
  logic        useImm = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [1:0]  amtSel = '0;
  logic [63:0] result;
  logic        writeEn;
  logic        ovfTrap;

  int checks = 0;
  int fails  = 0;
  logic [63:0] expRes = '0;

  always #10 clk = ~clk;

  alu64_trap dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .wordMode(wordMode), .useImm(useImm), .srcA(srcA), .srcB(srcB),
    .imm(imm), .shamt(shamt), .amtSel(amtSel),
    .result(result), .writeEn(writeEn), .ovfTrap(ovfTrap)
  );

  function automatic logic [63:0] corner(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'hFFFF_FFFF_FFFF_FFFF;
      5: return 64'h0000_0000_7FFF_FFFF;
      6: return 64'hFFFF_FFFF_8000_0000;
      default: return 64'h1234_5678_9ABC_DEF3;
    endcase
  endfunction

  // Arithmetic reference model: returns {write, trap, value}
  function automatic logic [65:0] model(input int op, input logic wm, input logic ui,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [15:0] im, input logic [4:0] sh,
                                        input logic [1:0] ss);
    logic [63:0] bv, res;
    logic        ov;
    longint      x, y, r;
    logic signed [64:0] r65;
    int          n;
    logic [31:0] w;
    ov = 1'b0;
    res = '0;
    if (ui) bv = (op <= 3 || op == 8 || op == 9) ? {{48{im[15]}}, im} : {48'h0, im};
    else    bv = b;
    case (op)
      0, 1, 2, 3: begin
        if (wm) begin
          x = longint'($signed(a[31:0]));
          y = longint'($signed(bv[31:0]));
          r = (op >= 2) ? x - y : x + y;
          ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
          res = {{32{r[31]}}, r[31:0]};
        end else begin
          r65 = (op >= 2) ? ($signed({a[63], a}) - $signed({bv[63], bv}))
                          : ($signed({a[63], a}) + $signed({bv[63], bv}));
          ov = r65[64] != r65[63];
          res = r65[63:0];
        end
        if (op == 1 || op == 3) ov = 1'b0;
      end
      4: res = a & bv;
      5: res = a | bv;
      6: res = a ^ bv;
      7: res = ~(a | bv);
      8: res = {63'h0, $signed(a) < $signed(bv)};
      9: res = {63'h0, a < bv};
      10: res = {{32{im[15]}}, im, 16'h0};
      11, 12, 13: begin
        n = (ss >= 2) ? int'(a[5:0]) : ((ss == 1) ? int'(sh) + 32 : int'(sh));
        if (wm) begin
          n = n % 32;
          w = b[31:0];
          if (op == 11)      w = w << n;
          else if (op == 12) w = w >> n;
          else begin
            x = longint'($signed(b[31:0])) >>> n;
            w = x[31:0];
          end
          res = {{32{w[31]}}, w};
        end else begin
          if (op == 11)      res = b << n;
          else if (op == 12) res = b >> n;
          else               res = $signed(b) >>> n;
        end
      end
      default: return {1'b0, 1'b0, 64'h0};
    endcase
    if (ov) return {1'b0, 1'b1, res};
    return {1'b1, 1'b0, res};
  endfunction

  task automatic check(input string tag, input logic eWe, input logic eOv, input logic [63:0] eRes);
    checks++;
    if (writeEn !== eWe || ovfTrap !== eOv || result !== eRes) begin
      fails++;
      $display("FAIL %s: got we=%0b trap=%0b res=%h, expected we=%0b trap=%0b res=%h",
               tag, writeEn, ovfTrap, result, eWe, eOv, eRes);
    end
  endtask

  task automatic apply(input string tag, input logic v, input int op, input logic wm,
                       input logic ui, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input logic [1:0] ss);
    logic [65:0] m;
    opValid = v; opCode = 4'(op); wordMode = wm; useImm = ui;
    srcA = a; srcB = b; imm = im; shamt = sh; amtSel = ss;
    m = v ? model(op, wm, ui, a, b, im, sh, ss) : 66'h0;
    if (m[65]) expRes = m[63:0];
    @(posedge clk);
    @(negedge clk);
    check(tag, m[65], m[64], expRes);
  endtask

  function automatic string tagFor(input int op, input logic wm, input logic ui,
                                   input logic trap, input logic [63:0] a, input logic [63:0] b);
    if (trap) return "R3";
    if ((op == 1 || op == 3) && a[63] != b[63]) return "R4";
    if (ui && op <= 9 && op != 10) return "R5";
    if (op <= 3)  return wm ? "R2" : "R1";
    if (op <= 7)  return "R6";
    if (op <= 9)  return "R7";
    if (op == 10) return "R8";
    if (op <= 13) return wm ? "R10" : "R9";
    return "R11";
  endfunction

  initial begin
    #(20ns * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [65:0] mm;
    logic [15:0] im;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R12", 1'b0, 1'b0, 64'h0);
    rst = 1'b0;

    // R3 directed: load 11, then a trapping overflow must leave it
    apply("R1", 1'b1, 1, 1'b0, 1'b0, 64'd5, 64'd6, 16'h0, 5'd0, 2'd0);
    apply("R3", 1'b1, 0, 1'b0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 5'd0, 2'd0);
    apply("R3", 1'b1, 2, 1'b1, 1'b0, 64'h8000_0000, 64'd1, 16'h0, 5'd0, 2'd0);
    // R11 directed: idle cycle and reserved code leave the result
    apply("R11", 1'b0, 1, 1'b0, 1'b0, 64'd9, 64'd9, 16'h0, 5'd0, 2'd0);
    apply("R11", 1'b1, 15, 1'b0, 1'b0, 64'd9, 64'd9, 16'h0, 5'd0, 2'd0);
    // R8 directed
    apply("R8", 1'b1, 10, 1'b0, 1'b1, 64'd0, 64'd0, 16'h8001, 5'd0, 2'd0);

    // Sweep
    for (int op = 0; op < 16; op++)
      for (int wm = 0; wm < 2; wm++)
        for (int ui = 0; ui < 2; ui++)
          for (int ss = 0; ss < 4; ss++)
            for (int i = 0; i < 8; i++)
              for (int j = 0; j < 8; j++) begin
                im = 16'(j * 16'h2493) | ((j % 2 == 1) ? 16'h8000 : 16'h0);
                mm = model(op, 1'(wm), 1'(ui), corner(i), corner(j), im,
                           5'(i * 5 + j * 3 + ss), 2'(ss));
                apply(tagFor(op, 1'(wm), 1'(ui), mm[64], corner(i), corner(j)),
                      1'b1, op, 1'(wm), 1'(ui), corner(i), corner(j), im,
                      5'(i * 5 + j * 3 + ss), 2'(ss));
              end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule